// File: doc/BRIEF.md
# Fault Recovery Supervisor

This block sits between a set of fault detectors and the parts of a processing system that can be forced back to a known state. Each detector delivers one-cycle event pulses. The block counts them per recovery rule. Once a rule has seen its configured number of events, it drives a hold (reset) line toward that rule's target group. The hold stays asserted for a configured number of timebase ticks. While a target's hold line is high, that target is kept in its nominal reset state and delivers no data. The targets are the programmable-logic region, the processor, the compute channel and the monitor channel.

The block also watches periodic heartbeat pulses from processor functions. A heartbeat channel that stays silent for too many ticks produces a missing-data event, and that event feeds the single-shot processor recovery rule. Durations and timeouts are counted in ticks of a slow timebase strobe. All thresholds, durations and timeouts are parameters.

No data stream passes through the block, so it has no valid/ready handshake and no back-pressure rules. Every pin is a plain control or status signal, sampled on the rising clock edge.

Top module: `frs_supervisor`

## Requirements
- R1: After reset, all four hold outputs and every watchdog miss bit are low.
- R2: A rule fires on the clock edge that samples its Nth counted event, and its hold output is high from that edge on. The thresholds are: upset 2, channel missing-data 2, out-of-range 2 per channel, compute/monitor discrepancy 3, and single missing-data 1.
- R3: Two configuration-upset events assert `hold_pl_o` for DUR_PL (default 8) ticks.
- R4: Missing-data events from either channel share one counter. Two such events assert `hold_cpu_o` for DUR_CPU (default 3) ticks.
- R5: Out-of-range events have a separate counter for each channel. Two events from one channel assert only that channel's hold for DUR_CHAN (default 3) ticks.
- R6: Three discrepancy events assert both `hold_c_o` and `hold_m_o` for DUR_BOTH (default 3) ticks.
- R7: A single comparator missing-data event, or a watchdog miss on any channel, asserts `hold_cpu_o` for DUR_SINGLE (default 10) ticks.
- R8: A fired rule counts down on each tick edge after the edge that fired it. A tick on the firing edge itself is not counted. The hold drops on the edge of the Dth tick.
- R9: Firing clears the rule's counter. Events that reach a rule while its own recovery is running are discarded and are not counted toward its next firing.
- R10: When several rules drive the same target, that target's hold stays high until the last of their timers has expired.
- R11: A watchdog channel with no heartbeat for WD_TIMEOUT (default 5) tick edges raises its miss bit for one cycle and then restarts its count. A heartbeat resets the count. While `hold_cpu_o` is high, all watchdog counts are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| upset_i | input | 1 | Configuration-memory upset event |
| nodata_c_i | input | 1 | Missing-data event from the compute channel |
| nodata_m_i | input | 1 | Missing-data event from the monitor channel |
| oor_c_i | input | 1 | Out-of-range event from the compute channel |
| oor_m_i | input | 1 | Out-of-range event from the monitor channel |
| mismatch_i | input | 1 | Compute/monitor discrepancy event |
| cmp_nodata_i | input | 1 | Missing-data event from the comparator |
| heartbeat_i | input | NUM_WD | Heartbeat pulses, one bit per watched function |
| hold_pl_o | output | 1 | Hold the programmable-logic region in reset |
| hold_cpu_o | output | 1 | Hold the processor in reset |
| hold_c_o | output | 1 | Hold the compute channel in reset |
| hold_m_o | output | 1 | Hold the monitor channel in reset |
| wd_miss_o | output | NUM_WD | One-cycle heartbeat timeout flag per channel |

## Verification
The hardest situation to reach from the ports is two rules with different remaining times driving the processor at once. A related case is a watchdog that times out, fires a processor hold, and must then stay quiet for the whole hold. Directed sequences set these up on purpose: one fires the channel missing-data rule, lets a tick pass, and then fires the single-shot rule; another leaves one heartbeat channel silent across a hold. A long seeded random run then mixes sparse events, irregular ticks and gappy heartbeats. In that run, a cycle-level reference in the bench predicts every hold and miss bit, so ignored events, ticks that coincide with firing edges and restarted counts all appear without being scripted.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam int N_RULES = 6;
  localparam int N_TGT   = 4;

  // rule slots
  localparam int RL_UPSET  = 0;
  localparam int RL_NODATA = 1;
  localparam int RL_OOR_C  = 2;
  localparam int RL_OOR_M  = 3;
  localparam int RL_MISM   = 4;
  localparam int RL_SINGLE = 5;

  // target slots
  localparam int TG_PL  = 0;
  localparam int TG_CPU = 1;
  localparam int TG_CHC = 2;
  localparam int TG_CHM = 3;

  // which rules drive each target
  localparam logic [N_RULES-1:0] TGT_RULES [N_TGT] = '{
    6'b000001,   // PL
    6'b100010,   // CPU
    6'b010100,   // compute channel
    6'b011000    // monitor channel
  };
endpackage

// File: rtl/frs_rule.sv
module frs_rule #(
  parameter int THRESH = 2,
  parameter int DUR    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic evt_i,
  output logic active_o
);
  localparam int CW = (THRESH > 1) ? $clog2(THRESH) : 1;
  localparam int TW = $clog2(DUR + 1);

  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;

  assign active_o = (tmr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmr <= '0;
    end else if (tmr != '0) begin
      if (tick_i) tmr <= tmr - TW'(1);
    end else if (evt_i) begin
      if (cnt == CW'(THRESH - 1)) begin
        cnt <= '0;
        tmr <= TW'(DUR);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2
  always_comb begin
    if (rst_n) cnt_bound_chk: assert (int'(cnt) < THRESH);
  end

  // R2
  fire_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(evt_i));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (cnt == '0));

  // R8
  tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && tick_i) |=> (tmr == $past(tmr) - TW'(1)));
endmodule

// File: rtl/frs_watchdog.sv
module frs_watchdog #(
  parameter int NUM_CH  = 2,
  parameter int TIMEOUT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              suspend_i,
  input  logic [NUM_CH-1:0] hb_i,
  output logic [NUM_CH-1:0] miss_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt        <= '0;
        miss_o[ch] <= 1'b0;
      end else begin
        miss_o[ch] <= 1'b0;
        if (suspend_i || hb_i[ch]) begin
          cnt <= '0;
        end else if (tick_i) begin
          if (cnt == CW'(TIMEOUT - 1)) begin
            cnt        <= '0;
            miss_o[ch] <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end

    // R11
    miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o[ch] |-> ($past(tick_i) && !$past(hb_i[ch]) && !$past(suspend_i)));

    // R11
    suspend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_i |=> !miss_o[ch]);
  end
endmodule

// File: rtl/frs_supervisor.sv
module frs_supervisor
  import frs_pkg::*;
#(
  parameter int THR_UPSET  = 2,
  parameter int THR_NODATA = 2,
  parameter int THR_OOR    = 2,
  parameter int THR_MISM   = 3,
  parameter int THR_SINGLE = 1,
  parameter int DUR_PL     = 8,
  parameter int DUR_CPU    = 3,
  parameter int DUR_CHAN   = 3,
  parameter int DUR_BOTH   = 3,
  parameter int DUR_SINGLE = 10,
  parameter int NUM_WD     = 2,
  parameter int WD_TIMEOUT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              upset_i,
  input  logic              nodata_c_i,
  input  logic              nodata_m_i,
  input  logic              oor_c_i,
  input  logic              oor_m_i,
  input  logic              mismatch_i,
  input  logic              cmp_nodata_i,
  input  logic [NUM_WD-1:0] heartbeat_i,
  output logic              hold_pl_o,
  output logic              hold_cpu_o,
  output logic              hold_c_o,
  output logic              hold_m_o,
  output logic [NUM_WD-1:0] wd_miss_o
);
  localparam int RULE_THR [N_RULES] = '{THR_UPSET, THR_NODATA, THR_OOR,
                                        THR_OOR, THR_MISM, THR_SINGLE};
  localparam int RULE_DUR [N_RULES] = '{DUR_PL, DUR_CPU, DUR_CHAN,
                                        DUR_CHAN, DUR_BOTH, DUR_SINGLE};

  logic [N_RULES-1:0] rule_evt;
  logic [N_RULES-1:0] rule_act;
  logic [N_TGT-1:0]   hold;

  assign rule_evt[RL_UPSET]  = upset_i;
  assign rule_evt[RL_NODATA] = nodata_c_i | nodata_m_i;
  assign rule_evt[RL_OOR_C]  = oor_c_i;
  assign rule_evt[RL_OOR_M]  = oor_m_i;
  assign rule_evt[RL_MISM]   = mismatch_i;
  assign rule_evt[RL_SINGLE] = cmp_nodata_i | (|wd_miss_o);

  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    frs_rule #(
      .THRESH(RULE_THR[r]),
      .DUR   (RULE_DUR[r])
    ) rule_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .evt_i   (rule_evt[r]),
      .active_o(rule_act[r])
    );
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    assign hold[t] = |(rule_act & TGT_RULES[t]);
  end

  assign hold_pl_o  = hold[TG_PL];
  assign hold_cpu_o = hold[TG_CPU];
  assign hold_c_o   = hold[TG_CHC];
  assign hold_m_o   = hold[TG_CHM];

  frs_watchdog #(
    .NUM_CH (NUM_WD),
    .TIMEOUT(WD_TIMEOUT)
  ) wd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .suspend_i(hold_cpu_o),
    .hb_i     (heartbeat_i),
    .miss_o   (wd_miss_o)
  );

  // R3
  pl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_pl_o) |-> $past(upset_i));

  // R6
  both_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_c_o) && $rose(hold_m_o)) |-> ($past(mismatch_i) || ($past(oor_c_i) && $past(oor_m_i))));

  // R5
  chan_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_c_o) |-> ($past(oor_c_i) || $past(mismatch_i)));
endmodule

// File: tb/frs_supervisor_tb.sv
module frs_supervisor_tb_top;
  localparam int NW = 2;
  localparam int TO = 5;
  localparam int B_THR [6] = '{2, 2, 2, 2, 3, 1};
  localparam int B_DUR [6] = '{8, 3, 3, 3, 3, 10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tk = 1'b0;
  logic [6:0] ev = '0;   // 0 upset,1 nd_c,2 nd_m,3 oor_c,4 oor_m,5 mism,6 cmp_nd
  logic [NW-1:0] hb = '1;
  logic hold_pl, hold_cpu, hold_c, hold_m;
  logic [NW-1:0] wd_miss;

  int total = 0;
  int bad = 0;
  int miss0_seen = 0;

  always #5 clk = ~clk;

  frs_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tk),
    .upset_i(ev[0]), .nodata_c_i(ev[1]), .nodata_m_i(ev[2]),
    .oor_c_i(ev[3]), .oor_m_i(ev[4]), .mismatch_i(ev[5]),
    .cmp_nodata_i(ev[6]), .heartbeat_i(hb),
    .hold_pl_o(hold_pl), .hold_cpu_o(hold_cpu), .hold_c_o(hold_c),
    .hold_m_o(hold_m), .wd_miss_o(wd_miss)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-level reference
  int m_cnt [6];
  int m_tmr [6];
  int m_wd [NW];
  logic [NW-1:0] m_miss;

  function automatic logic [3:0] m_hold();
    logic [3:0] h;
    h[0] = (m_tmr[0] != 0);
    h[1] = (m_tmr[1] != 0) || (m_tmr[5] != 0);
    h[2] = (m_tmr[2] != 0) || (m_tmr[4] != 0);
    h[3] = (m_tmr[3] != 0) || (m_tmr[4] != 0);
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 6; r++) begin m_cnt[r] = 0; m_tmr[r] = 0; end
      for (int c = 0; c < NW; c++) m_wd[c] = 0;
      m_miss = '0;
    end else begin
      logic [5:0] e;
      logic hc;
      e = {ev[6] | (|m_miss), ev[5], ev[4], ev[3], ev[1] | ev[2], ev[0]};
      hc = m_hold()[1];
      for (int r = 0; r < 6; r++) begin
        if (m_tmr[r] != 0) begin
          if (tk) m_tmr[r]--;
        end else if (e[r]) begin
          if (m_cnt[r] + 1 == B_THR[r]) begin m_cnt[r] = 0; m_tmr[r] = B_DUR[r]; end
          else m_cnt[r]++;
        end
      end
      for (int c = 0; c < NW; c++) begin
        m_miss[c] = 1'b0;
        if (hc || hb[c]) m_wd[c] = 0;
        else if (tk) begin
          if (m_wd[c] == TO - 1) begin m_wd[c] = 0; m_miss[c] = 1'b1; end
          else m_wd[c]++;
        end
      end
      if (wd_miss[0]) miss0_seen++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] h;
      h = m_hold();
      chk(32'(hold_pl), 32'(h[0]), "R3 model");
      chk(32'(hold_cpu), 32'(h[1]), "R4 model");
      chk(32'(hold_c), 32'(h[2]), "R5 model");
      chk(32'(hold_m), 32'(h[3]), "R6 model");
      chk(32'(wd_miss), 32'(m_miss), "R11 model");
    end
  end

  task automatic pulse(input int k);
    @(negedge clk) ev[k] = 1'b1;
    @(negedge clk) ev[k] = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tk = 1'b1;
      @(negedge clk) tk = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(32'({hold_pl, hold_cpu, hold_c, hold_m, wd_miss}), 0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'({hold_pl, hold_cpu, hold_c, hold_m, wd_miss}), 0, "R1 after reset");

    // upset rule, duration, discarded events
    pulse(0);
    chk(32'(hold_pl), 0, "R2 one upset");
    pulse(0);
    chk(32'(hold_pl), 1, "R3 two upsets");
    pulse(0); pulse(0);
    ticks(7);
    chk(32'(hold_pl), 1, "R8 before last tick");
    ticks(1);
    chk(32'(hold_pl), 0, "R8 after last tick");
    pulse(0);
    chk(32'(hold_pl), 0, "R9 ignored events not counted");
    pulse(0);
    chk(32'(hold_pl), 1, "R3 refire");
    ticks(8);
    chk(32'(hold_pl), 0, "R3 refire expiry");

    // shared channel missing-data counter
    pulse(1); pulse(2);
    chk(32'({hold_cpu, hold_c, hold_m}), 3'b100, "R4 either channel");
    ticks(3);
    chk(32'(hold_cpu), 0, "R4 expiry");

    // out-of-range on one channel
    pulse(3);
    chk(32'(hold_c), 0, "R5 first oor");
    pulse(3);
    chk(32'({hold_c, hold_m, hold_cpu}), 3'b100, "R5 compute only");
    ticks(3);
    chk(32'(hold_c), 0, "R5 expiry");

    // discrepancy
    pulse(5); pulse(5);
    chk(32'({hold_c, hold_m}), 0, "R6 two discrepancies");
    pulse(5);
    chk(32'({hold_c, hold_m}), 2'b11, "R6 third discrepancy");
    ticks(3);
    chk(32'({hold_c, hold_m}), 0, "R6 expiry");

    // single-shot
    pulse(6);
    chk(32'(hold_cpu), 1, "R7 single event");
    ticks(9);
    chk(32'(hold_cpu), 1, "R7 before expiry");
    ticks(1);
    chk(32'(hold_cpu), 0, "R7 expiry");

    // overlap on the processor
    pulse(1); pulse(1);
    ticks(1);
    pulse(6);
    ticks(2);
    chk(32'(hold_cpu), 1, "R10 short timer done");
    ticks(7);
    chk(32'(hold_cpu), 1, "R10 long timer running");
    ticks(1);
    chk(32'(hold_cpu), 0, "R10 long timer done");

    // watchdog
    @(negedge clk) hb = 2'b10;
    ticks(4);
    chk(32'(wd_miss), 0, "R11 before timeout");
    ticks(1);
    chk(32'(wd_miss), 2'b01, "R11 timeout");
    @(negedge clk);
    chk(32'({hold_cpu, wd_miss}), 3'b100, "R7 watchdog hold");
    ticks(10);
    chk(32'(hold_cpu), 0, "R7 watchdog hold expiry");
    chk(miss0_seen, 1, "R11 suspended in hold");
    ticks(4);
    chk(miss0_seen, 1, "R11 restarted count");
    ticks(1);
    @(negedge clk);
    chk(miss0_seen, 2, "R11 second timeout");
    hb = '1;

    // random phase
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tk = ($urandom % 4) == 0;
      for (int k = 0; k < 7; k++) ev[k] = ($urandom % 10) == 0;
      for (int c = 0; c < NW; c++) hb[c] = ($urandom % 18) == 0;
    end
    @(negedge clk);
    ev = '0; tk = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule